// File: doc/BRIEF.md
# Host Register Port for a Serial Communications Controller

This block is the processor-facing register port of a serial communications controller. A 3-bit address reaches four 16-bit internal registers, each accessible as a whole word or as either of its two bytes. The low byte of each register holds data and the high byte holds control and status. The processor sets up address, chip enable, byte select and direction, then raises the bus strobe. A read drives the bus while the strobe is high. A write captures the bus once, at the first clock edge of the strobe.

The block produces one-cycle strobes toward the serial engines. A low-byte read of the receive data/status register tells the receiver that its character was taken. A high-byte read tells it that its status was taken. Any write to the transmit data/status register gives a load pulse to the transmitter. That write also clears the transmit-buffer-empty flag, which the transmitter sets when it wants more data.

The tri-state data bus is modelled as a data output plus an output enable, so the pad ring outside the block can build the bidirectional pin.

Top module: `cbus_port`

## Requirements
- R1: While rst_ni is low, and afterwards until a write, ctl_o, aux_o, tx_dsr_o, tx_empty_o, rx_data_rd_o, rx_stat_rd_o, tx_wr_o and dat_oe_o are all zero.
- R2: dat_oe_o is high only when ce_i and strb_i are high and wr_i is low (read). It follows these inputs in the same cycle. dat_o is zero whenever dat_oe_o is low.
- R3: addr_i[2:1] picks the register: 0 control (ctl_o), 1 auxiliary (aux_o), 2 receive data/status (read-only, reads return rx_dsr_i), 3 transmit data/status (tx_dsr_o). In word mode (byte_i=0), addr_i[0] is ignored and a read returns the full 16-bit register.
- R4: A word write (wr_i=1) stores dat_i at the first rising clock edge at which ce_i and strb_i are both high. A strobe held over later edges writes nothing more, so data changed while the strobe is held is ignored.
- R5: In byte mode (byte_i=1), addr_i[0]=0 selects bits 7:0 and addr_i[0]=1 selects bits 15:8. A byte write takes its value from dat_i[7:0] and leaves the other byte unchanged.
- R6: A byte read presents the selected byte on both dat_o[7:0] and dat_o[15:8].
- R7: In the cycle after the start edge of a read of register 2, rx_data_rd_o pulses if the low byte was read and rx_stat_rd_o pulses if the high byte was read. A word read pulses both. Each pulse lasts one cycle. Writes to register 2 change nothing and produce no pulse.
- R8: Any write (word or either byte) to register 3 gives a one-cycle tx_wr_o pulse in the cycle after the start edge. The same write clears tx_empty_o from that cycle.
- R9: tx_req_i high at a clock edge sets tx_empty_o from the next cycle. If a register 3 write starts at the same edge, the clear wins.
- R10: With ce_i low, a strobe has no effect: no write, no pulse, no bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address; bit 0 picks the byte in byte mode |
| byte_i | input | 1 | 1 = byte transfer, 0 = word transfer |
| ce_i | input | 1 | Chip enable, active high |
| wr_i | input | 1 | Direction: 1 = write, 0 = read |
| strb_i | input | 1 | Data bus strobe, active high |
| dat_i | input | 16 | Bus data from the processor |
| dat_o | output | 16 | Bus data to the processor |
| dat_oe_o | output | 1 | Drive enable for the bus pads |
| rx_dsr_i | input | 16 | Receive data/status word from the receiver |
| tx_req_i | input | 1 | Transmitter requests new data |
| ctl_o | output | 16 | Control register contents |
| aux_o | output | 16 | Auxiliary register contents |
| tx_dsr_o | output | 16 | Transmit data/status register contents |
| tx_empty_o | output | 1 | Transmit-buffer-empty flag |
| rx_data_rd_o | output | 1 | Receive data byte was read |
| rx_stat_rd_o | output | 1 | Receive status byte was read |
| tx_wr_o | output | 1 | Transmit register was written |

## Verification
Read data and the bus enable are combinational, so the bench samples them one time unit after it drives the inputs, in the same cycle. Register contents, the three strobes and the buffer-empty flag change at the start edge of the strobe. The bench samples them at the falling edge after that edge, and samples once more a cycle later to confirm that each strobe has dropped. All inputs change on falling edges, so no result depends on how processes are ordered at a rising edge.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef enum logic [1:0] {
    REG_CTL = 2'd0,
    REG_AUX = 2'd1,
    REG_RXD = 2'd2,
    REG_TXD = 2'd3
  } reg_idx_e;

  localparam int RX_IDX = int'(REG_RXD);
  localparam int TX_IDX = int'(REG_TXD);
endpackage

// File: rtl/cbus_decode.sv
module cbus_decode #(
  parameter int AW   = 3,
  parameter int IW   = AW - 1,
  parameter int NREG = 2 ** IW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            byte_i,
  input  logic            ce_i,
  input  logic            wr_i,
  input  logic            strb_i,
  output logic [IW-1:0]   idx_o,
  output logic            hi_sel_o,
  output logic            oe_o,
  output logic [NREG-1:0] wr_lo_o,
  output logic [NREG-1:0] wr_hi_o,
  output logic [NREG-1:0] rd_lo_o,
  output logic [NREG-1:0] rd_hi_o
);
  logic act, act_q, start;
  logic lane_lo, lane_hi;

  assign act      = ce_i & strb_i;
  assign start    = act & ~act_q;
  assign idx_o    = addr_i[AW-1:1];
  assign hi_sel_o = addr_i[0];
  assign oe_o     = act & ~wr_i;
  // word access touches both lanes; byte access one
  assign lane_lo  = ~byte_i | ~addr_i[0];
  assign lane_hi  = ~byte_i |  addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    logic hit;
    assign hit        = start && (idx_o == IW'(g));
    assign wr_lo_o[g] = hit &  wr_i & lane_lo;
    assign wr_hi_o[g] = hit &  wr_i & lane_hi;
    assign rd_lo_o[g] = hit & ~wr_i & lane_lo;
    assign rd_hi_o[g] = hit & ~wr_i & lane_hi;
  end
endmodule

// File: rtl/cbus_regs.sv
module cbus_regs #(
  parameter int NREG   = 4,
  parameter int DW     = 16,
  parameter int RO_IDX = 2,
  localparam int BW    = DW / 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NREG-1:0]         wr_lo_i,
  input  logic [NREG-1:0]         wr_hi_i,
  input  logic [DW-1:0]           wd_i,
  input  logic [DW-1:0]           ro_val_i,
  output logic [NREG-1:0][DW-1:0] q_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == RO_IDX) begin : g_ro
      logic unused_wr;
      assign unused_wr = wr_lo_i[g] | wr_hi_i[g];
      assign q_o[g]    = ro_val_i;
    end else begin : g_rw
      logic [BW-1:0] lo_q, hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_q <= '0;
          hi_q <= '0;
        end else begin
          if (wr_lo_i[g]) lo_q <= wd_i[BW-1:0];
          if (wr_hi_i[g]) hi_q <= wd_i[DW-1:BW];
        end
      end
      assign q_o[g] = {hi_q, lo_q};
    end
  end
endmodule

// File: rtl/cbus_rdmux.sv
module cbus_rdmux #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  parameter int IW   = $clog2(NREG),
  localparam int BW  = DW / 2
) (
  input  logic [NREG-1:0][DW-1:0] q_i,
  input  logic [IW-1:0]           idx_i,
  input  logic                    hi_sel_i,
  input  logic                    byte_i,
  input  logic                    oe_i,
  output logic [DW-1:0]           dat_o
);
  logic [DW-1:0] word;
  logic [BW-1:0] sel_b;

  always_comb begin
    word  = q_i[idx_i];
    sel_b = hi_sel_i ? word[DW-1:BW] : word[BW-1:0];
    if (!oe_i)       dat_o = '0;
    else if (byte_i) dat_o = {sel_b, sel_b};
    else             dat_o = word;
  end
endmodule

// File: rtl/cbus_port.sv
module cbus_port
  import cbus_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          byte_i,
  input  logic          ce_i,
  input  logic          wr_i,
  input  logic          strb_i,
  input  logic [DW-1:0] dat_i,
  output logic [DW-1:0] dat_o,
  output logic          dat_oe_o,
  input  logic [DW-1:0] rx_dsr_i,
  input  logic          tx_req_i,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] aux_o,
  output logic [DW-1:0] tx_dsr_o,
  output logic          tx_empty_o,
  output logic          rx_data_rd_o,
  output logic          rx_stat_rd_o,
  output logic          tx_wr_o
);
  localparam int IW   = AW - 1;
  localparam int NREG = 2 ** IW;
  localparam int BW   = DW / 2;

  logic [IW-1:0]           idx;
  logic                    hi_sel, oe;
  logic [NREG-1:0]         wr_lo, wr_hi, rd_lo, rd_hi;
  logic [NREG-1:0][DW-1:0] q;
  logic [DW-1:0]           wd;
  logic                    tx_load;
  logic                    rx_data_q, rx_stat_q, tx_wr_q, tx_empty_q;

  cbus_decode #(.AW(AW), .IW(IW), .NREG(NREG)) u_dec (
    .clk_i, .rst_ni, .addr_i, .byte_i, .ce_i, .wr_i, .strb_i,
    .idx_o(idx), .hi_sel_o(hi_sel), .oe_o(oe),
    .wr_lo_o(wr_lo), .wr_hi_o(wr_hi), .rd_lo_o(rd_lo), .rd_hi_o(rd_hi)
  );

  // byte writes come in on the low lanes
  assign wd = byte_i ? {dat_i[BW-1:0], dat_i[BW-1:0]} : dat_i;

  cbus_regs #(.NREG(NREG), .DW(DW), .RO_IDX(RX_IDX)) u_regs (
    .clk_i, .rst_ni, .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wd_i(wd), .ro_val_i(rx_dsr_i), .q_o(q)
  );

  cbus_rdmux #(.NREG(NREG), .DW(DW), .IW(IW)) u_rdmux (
    .q_i(q), .idx_i(idx), .hi_sel_i(hi_sel), .byte_i, .oe_i(oe), .dat_o
  );

  assign tx_load = wr_lo[TX_IDX] | wr_hi[TX_IDX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q  <= 1'b0;
      rx_stat_q  <= 1'b0;
      tx_wr_q    <= 1'b0;
      tx_empty_q <= 1'b0;
    end else begin
      rx_data_q <= rd_lo[RX_IDX];
      rx_stat_q <= rd_hi[RX_IDX];
      tx_wr_q   <= tx_load;
      if (tx_load)       tx_empty_q <= 1'b0;
      else if (tx_req_i) tx_empty_q <= 1'b1;
    end
  end

  logic unused_rd;
  assign unused_rd = ^{rd_lo, rd_hi};

  assign dat_oe_o     = oe;
  assign ctl_o        = q[int'(REG_CTL)];
  assign aux_o        = q[int'(REG_AUX)];
  assign tx_dsr_o     = q[TX_IDX];
  assign tx_empty_o   = tx_empty_q;
  assign rx_data_rd_o = rx_data_q;
  assign rx_stat_rd_o = rx_stat_q;
  assign tx_wr_o      = tx_wr_q;
endmodule

// File: rtl/cbus_port_chk.sv
module cbus_port_chk #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          byte_i,
  input logic          ce_i,
  input logic          wr_i,
  input logic          strb_i,
  input logic [DW-1:0] dat_i,
  input logic [DW-1:0] dat_o,
  input logic          dat_oe_o,
  input logic [DW-1:0] tx_dsr_o,
  input logic          tx_empty_o,
  input logic          rx_data_rd_o,
  input logic          rx_stat_rd_o,
  input logic          tx_wr_o
);
  localparam int BW = DW / 2;

  AST_OE_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_oe_o |-> (ce_i && strb_i && !wr_i)) else $error("oe"); // R2

  AST_WORD_WR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_o && $past(byte_i) == 1'b0) |-> tx_dsr_o == $past(dat_i)) else $error("wr"); // R4

  AST_BYTE_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_oe_o && byte_i) |-> dat_o[DW-1:BW] == dat_o[BW-1:0]) else $error("mirror"); // R6

  AST_RXSTAT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stat_rd_o |-> $past(ce_i && strb_i && !wr_i && addr_i[AW-1:1] == 2'd2
                           && (!byte_i || addr_i[0]))) else $error("rxstat"); // R7

  AST_RXDATA_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_data_rd_o |=> !rx_data_rd_o) else $error("rxpulse"); // R7

  AST_TXWR_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_o |-> !tx_empty_o) else $error("txe"); // R8

  AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |-> !dat_oe_o) else $error("ce"); // R10
endmodule

bind cbus_port cbus_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .addr_i, .byte_i, .ce_i, .wr_i, .strb_i, .dat_i,
  .dat_o, .dat_oe_o, .tx_dsr_o, .tx_empty_o, .rx_data_rd_o,
  .rx_stat_rd_o, .tx_wr_o
);

// File: tb/cbus_port_test.sv
module cbus_port_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        byte_i = 1'b0, ce_i = 1'b0, wr_i = 1'b0, strb_i = 1'b0;
  logic [15:0] dat_i = '0, rx_dsr_i = '0;
  logic        tx_req_i = 1'b0;
  logic [15:0] dat_o, ctl_o, aux_o, tx_dsr_o;
  logic        dat_oe_o, tx_empty_o, rx_data_rd_o, rx_stat_rd_o, tx_wr_o;

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cbus_port uut (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one access: rd/oe sampled during strobe, p* after start edge, a* one cycle later
  logic [15:0] rd;
  logic        oe, p_rl, p_rh, p_tw, a_rl, a_rh, a_tw;

  task automatic acc(input logic w, input logic [2:0] a, input logic b,
                     input logic c, input logic [15:0] d, input logic req);
    @(negedge clk_i);
    wr_i = w; addr_i = a; byte_i = b; ce_i = c; dat_i = d; strb_i = 1'b1; tx_req_i = req;
    #1 rd = dat_o; oe = dat_oe_o;
    @(negedge clk_i);
    p_rl = rx_data_rd_o; p_rh = rx_stat_rd_o; p_tw = tx_wr_o;
    strb_i = 1'b0; ce_i = 1'b0; wr_i = 1'b0; tx_req_i = 1'b0;
    @(negedge clk_i);
    a_rl = rx_data_rd_o; a_rh = rx_stat_rd_o; a_tw = tx_wr_o;
  endtask

  task automatic t_reset;
    chk("R1 ctl", ctl_o, 16'h0);
    chk("R1 aux", aux_o, 16'h0);
    chk("R1 txdsr", tx_dsr_o, 16'h0);
    chk("R1 flags", {11'b0, dat_oe_o, tx_empty_o, rx_data_rd_o, rx_stat_rd_o, tx_wr_o}, 16'h0);
  endtask

  task automatic t_hiz;
    acc(1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0);
    chk("R2 ce low no drive", {15'b0, oe}, 16'h0);
    chk("R2 dat zero", rd, 16'h0);
    acc(1'b1, 3'd2, 1'b0, 1'b1, 16'h0000, 1'b0);
    chk("R2 write no drive", {15'b0, oe}, 16'h0);
    @(negedge clk_i); ce_i = 1'b1; #1;
    chk("R2 strobe low no drive", {15'b0, dat_oe_o}, 16'h0);
    ce_i = 1'b0;
  endtask

  task automatic t_word;
    acc(1'b1, 3'd0, 1'b0, 1'b1, 16'hA55A, 1'b0);
    chk("R4 ctl word write", ctl_o, 16'hA55A);
    acc(1'b1, 3'd3, 1'b0, 1'b1, 16'h1234, 1'b0);
    chk("R3 aux via odd addr", aux_o, 16'h1234);
    acc(1'b0, 3'd1, 1'b0, 1'b1, 16'h0, 1'b0);
    chk("R3 word read ctl", rd, 16'hA55A);
    chk("R2 read drives", {15'b0, oe}, 16'h1);
    acc(1'b0, 3'd2, 1'b0, 1'b1, 16'h0, 1'b0);
    chk("R3 word read aux", rd, 16'h1234);
  endtask

  task automatic t_held;
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 3'd2; byte_i = 1'b0; ce_i = 1'b1; dat_i = 16'h00FF; strb_i = 1'b1;
    @(negedge clk_i); dat_i = 16'hFFFF;
    @(negedge clk_i); @(negedge clk_i);
    strb_i = 1'b0; ce_i = 1'b0; wr_i = 1'b0;
    @(negedge clk_i);
    chk("R4 held strobe single write", aux_o, 16'h00FF);
  endtask

  task automatic t_byte;
    acc(1'b1, 3'd1, 1'b1, 1'b1, 16'h993C, 1'b0);
    chk("R5 high byte write", ctl_o, 16'h3C5A);
    acc(1'b1, 3'd0, 1'b1, 1'b1, 16'h6677, 1'b0);
    chk("R5 low byte write", ctl_o, 16'h3C77);
    acc(1'b0, 3'd1, 1'b1, 1'b1, 16'h0, 1'b0);
    chk("R6 high byte read mirrored", rd, 16'h3C3C);
    acc(1'b0, 3'd0, 1'b1, 1'b1, 16'h0, 1'b0);
    chk("R6 low byte read mirrored", rd, 16'h7777);
  endtask

  task automatic t_rx;
    rx_dsr_i = 16'hBEEF;
    acc(1'b0, 3'd4, 1'b1, 1'b1, 16'h0, 1'b0);
    chk("R7 rx low byte data", rd, 16'hEFEF);
    chk("R7 rx low pulses", {14'b0, p_rl, p_rh}, 16'h2);
    chk("R7 rx low pulse ends", {14'b0, a_rl, a_rh}, 16'h0);
    acc(1'b0, 3'd5, 1'b1, 1'b1, 16'h0, 1'b0);
    chk("R7 rx high byte data", rd, 16'hBEBE);
    chk("R7 rx high pulses", {14'b0, p_rl, p_rh}, 16'h1);
    acc(1'b0, 3'd4, 1'b0, 1'b1, 16'h0, 1'b0);
    chk("R3 rx word read", rd, 16'hBEEF);
    chk("R7 rx word pulses", {14'b0, p_rl, p_rh}, 16'h3);
    chk("R7 rx word pulses end", {14'b0, a_rl, a_rh}, 16'h0);
    acc(1'b1, 3'd4, 1'b0, 1'b1, 16'h1111, 1'b0);
    chk("R7 rx write no pulse", {13'b0, p_rl, p_rh, p_tw}, 16'h0);
    acc(1'b0, 3'd4, 1'b0, 1'b1, 16'h0, 1'b0);
    chk("R7 rx write ignored", rd, 16'hBEEF);
  endtask

  task automatic t_tx;
    @(negedge clk_i); tx_req_i = 1'b1;
    @(negedge clk_i); tx_req_i = 1'b0;
    chk("R9 req sets empty", {15'b0, tx_empty_o}, 16'h1);
    acc(1'b1, 3'd7, 1'b1, 1'b1, 16'h0081, 1'b0);
    chk("R8 tx pulse", {15'b0, p_tw}, 16'h1);
    chk("R8 tx pulse ends", {15'b0, a_tw}, 16'h0);
    chk("R8 empty cleared", {15'b0, tx_empty_o}, 16'h0);
    chk("R5 tx high byte", tx_dsr_o, 16'h8100);
    @(negedge clk_i); tx_req_i = 1'b1;
    @(negedge clk_i); tx_req_i = 1'b0;
    acc(1'b1, 3'd6, 1'b0, 1'b1, 16'h4242, 1'b1);
    chk("R9 clear wins over req", {15'b0, tx_empty_o}, 16'h0);
    chk("R8 tx word", tx_dsr_o, 16'h4242);
  endtask

  task automatic t_ce;
    acc(1'b1, 3'd0, 1'b0, 1'b0, 16'hDEAD, 1'b0);
    chk("R10 ce low no write", ctl_o, 16'h3C77);
    acc(1'b0, 3'd4, 1'b0, 1'b0, 16'h0, 1'b0);
    chk("R10 ce low no pulse", {13'b0, p_rl, p_rh, p_tw}, 16'h0);
    acc(1'b1, 3'd6, 1'b0, 1'b0, 16'hDEAD, 1'b0);
    chk("R10 ce low no tx write", tx_dsr_o, 16'h4242);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_hiz();
    t_word();
    t_held();
    t_byte();
    t_rx();
    t_tx();
    t_ce();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule